// File: doc/BRIEF.md
# Multiplexed ADC Acquisition Controller

This block sequences conversions for a 16-input multiplexed ADC and buffers the results in a 1024-entry sample FIFO. A host reaches it through a small register window. Host writes are eight bits wide. Host reads return a full 16-bit word, so one read of the FIFO location removes one whole sample.

A conversion can be started by a host strobe, by a tick from an external pacer counter, or by an external trigger pulse. The trigger control register selects the source. In auto-scan mode the channel presented to the multiplexer starts at 0 and steps up by one after each completed conversion. After the programmed last channel it returns to 0. With auto-scan off, every conversion uses the programmed channel. One 3-bit gain code applies to all channels.

The converter handshake is minimal. The block raises a one-cycle start pulse, and the converter later returns a one-cycle valid pulse together with the result. A status register reports converter activity and three active-low FIFO flags. Two interrupt request lines latch selectable events and are released by a write to the clear location.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset the status location (0x08) reads 0x60, the trigger control location (0x0A) reads 0x00, and both interrupt lines are low.
- R2: In the status byte, bit 7 is 1 while a conversion is in progress. Bit 6 is 0 when the FIFO is full, bit 5 is 0 when it holds at least half its depth, and bit 4 is 0 when it is empty. Bit 3 reads 0, and bits 2:0 hold the gain code.
- R3: Three consecutive writes to the interrupt control location (0x0C), with bit 2 equal to 0, then 1, then 0, empty the FIFO and release the sticky full flag. Any other pattern of those writes leaves the FIFO contents unchanged.
- R4: When trigger control bit 0 is set, successive conversions use channels 0, 1, up to the last channel written at 0x06, and then return to 0. Writing 0x06 or 0x0A restarts the sequence at channel 0. When bit 0 is clear, each conversion uses the channel written at 0x06.
- R5: The FIFO holds 1024 samples, and the half flag asserts at 512 entries. A result that completes while the FIFO is full is discarded. From that point the full flag stays asserted until an R3 reset, even if entries are later read.
- R6: Trigger control bit 1 selects the pacer tick as the only start source. Otherwise bit 2 selects the external trigger as the only start source. When both bits are clear, only a write to 0x0E starts a conversion.
- R7: A start request that arrives while a conversion is in progress is ignored.
- R8: Reading 0x0A returns the interrupt control bits 3:0 in bits 7:4 and the trigger control bits 2:0 in bits 2:0.
- R9: Interrupt control bit 0 selects the event for irq_a: 0 means a conversion has completed, 1 means the FIFO has just reached half full. Bit 1 selects the event for irq_b: 0 means a pacer tick, 1 means an external trigger. Any write to 0x48 lowers both lines.
- R10: Reading 0x00 returns the oldest stored sample and removes it from the FIFO.
- R11: Writing 0x08 stores a 3-bit gain code. The code drives gain_code and reads back in the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 7 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 16 | Read data (combinational on host_addr) |
| pacer_tick | input | 1 | Pacer counter tick |
| ext_trig | input | 1 | External trigger pulse |
| adc_start | output | 1 | Start-of-conversion pulse |
| adc_chan | output | 4 | Multiplexer channel select |
| adc_valid | input | 1 | Conversion result valid pulse |
| adc_data | input | 16 | Conversion result |
| gain_code | output | 3 | Gain code shared by all channels |
| irq_a | output | 1 | First interrupt request |
| irq_b | output | 1 | Second interrupt request |

## Verification
The bench targets the wrap of the auto-scan sequence at the last channel. A design with an off-by-one error there would skip a channel or go past the last one. It drives a second start request while a conversion is still in progress; a controller that accepted it would produce a duplicate sample. It fills the FIFO past its depth and then reads one entry. A design without the sticky full flag would report the FIFO as not full while samples had already been lost. It also writes an incomplete enable pattern, which a design that reset on any falling edge of the enable bit would wrongly treat as a FIFO reset.

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl #(
  parameter int NCH    = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [7:0]               host_wdata,
  output logic [DATA_W-1:0]        host_rdata,
  input  logic                     pacer_tick,
  input  logic                     ext_trig,
  output logic                     adc_start,
  output logic [$clog2(NCH)-1:0]   adc_chan,
  input  logic                     adc_valid,
  input  logic [DATA_W-1:0]        adc_data,
  output logic [2:0]               gain_code,
  output logic                     irq_a,
  output logic                     irq_b
);
  localparam int CH_W  = $clog2(NCH);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int HALF  = DEPTH / 2;
  localparam logic [ADDR_W-1:0] OFS_FIFO = ADDR_W'(7'h00);
  localparam logic [ADDR_W-1:0] OFS_CHAN = ADDR_W'(7'h06);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(7'h08);
  localparam logic [ADDR_W-1:0] OFS_TRIG = ADDR_W'(7'h0A);
  localparam logic [ADDR_W-1:0] OFS_ICTL = ADDR_W'(7'h0C);
  localparam logic [ADDR_W-1:0] OFS_SOFT = ADDR_W'(7'h0E);
  localparam logic [ADDR_W-1:0] OFS_ICLR = ADDR_W'(7'h48);

  logic [7:0]        chan_q;
  logic [2:0]        range_q;
  logic [2:0]        trig_q;
  logic [3:0]        ictl_q;
  logic [1:0]        seq_q;
  logic [CH_W-1:0]   scan_q;
  logic              busy_q, ovf_q, half_q, irq_a_q, irq_b_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;

  wire wr_chan = host_wr && host_addr == OFS_CHAN;
  wire wr_stat = host_wr && host_addr == OFS_STAT;
  wire wr_trig = host_wr && host_addr == OFS_TRIG;
  wire wr_ictl = host_wr && host_addr == OFS_ICTL;
  wire wr_soft = host_wr && host_addr == OFS_SOFT;
  wire wr_iclr = host_wr && host_addr == OFS_ICLR;

  wire fifo_clr = wr_ictl && !host_wdata[2] && seq_q == 2'd2;
  wire req      = trig_q[1] ? pacer_tick : (trig_q[2] ? ext_trig : wr_soft);
  wire done     = busy_q && adc_valid;
  wire full     = cnt == CNT_W'(DEPTH);
  wire empty    = cnt == '0;
  wire half_now = cnt >= CNT_W'(HALF);
  wire push     = done && !full;
  wire pop      = host_rd && host_addr == OFS_FIFO && !empty;
  wire set_a    = ictl_q[0] ? (half_now && !half_q) : done;
  wire set_b    = ictl_q[1] ? ext_trig : pacer_tick;

  assign adc_start = req && !busy_q;
  assign adc_chan  = trig_q[0] ? scan_q : chan_q[CH_W-1:0];
  assign gain_code = range_q;
  assign irq_a     = irq_a_q;
  assign irq_b     = irq_b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q  <= '0;
      range_q <= '0;
      trig_q  <= '0;
      ictl_q  <= '0;
      seq_q   <= '0;
      scan_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      if (adc_start) busy_q <= 1'b1;
      else if (adc_valid) busy_q <= 1'b0;
      if (done && trig_q[0])
        scan_q <= (scan_q == chan_q[CH_W-1:0]) ? '0 : scan_q + 1'b1;
      if (wr_chan) begin
        chan_q <= host_wdata;
        scan_q <= '0;
      end
      if (wr_trig) begin
        trig_q <= host_wdata[2:0];
        scan_q <= '0;
      end
      if (wr_stat) range_q <= host_wdata[2:0];
      if (wr_ictl) begin
        ictl_q <= host_wdata[3:0];
        if (!host_wdata[2]) seq_q <= 2'd1;
        else seq_q <= (seq_q == 2'd1) ? 2'd2 : 2'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      ovf_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt    <= cnt + CNT_W'(push) - CNT_W'(pop);
      half_q <= half_now;
      if (done && full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= adc_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_a_q <= 1'b0;
      irq_b_q <= 1'b0;
    end else begin
      if (set_a) irq_a_q <= 1'b1;
      else if (wr_iclr) irq_a_q <= 1'b0;
      if (set_b) irq_b_q <= 1'b1;
      else if (wr_iclr) irq_b_q <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_FIFO: host_rdata = empty ? '0 : mem[rp];
      OFS_CHAN: host_rdata[7:0] = chan_q;
      OFS_STAT: host_rdata[7:0] = {busy_q, !(full || ovf_q), !half_now, !empty, 1'b0, range_q};
      OFS_TRIG: host_rdata[7:0] = {ictl_q, 1'b0, trig_q};
      default:  host_rdata = '0;
    endcase
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !fifo_clr) |=> full);
  a_r7_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  a_r4_scan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q[0] |-> scan_q <= chan_q[CH_W-1:0]);
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (empty && !ovf_q));
  a_r9_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iclr && !set_a && !set_b) |=> (!irq_a && !irq_b));
endmodule

// File: tb/adc_acq_ctrl_test.sv
module adc_acq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  host_addr = '0;
  logic        host_wr = 0, host_rd = 0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] host_rdata;
  logic        pacer_tick = 0, ext_trig = 0;
  logic        adc_start;
  logic [3:0]  adc_chan;
  logic        adc_valid;
  logic [15:0] adc_data;
  logic [2:0]  gain_code;
  logic        irq_a, irq_b;

  int checks = 0, failures = 0;
  logic [15:0] expq[$];
  logic [11:0] eseq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_acq_ctrl uut (.clk, .rst_n, .host_addr, .host_wr, .host_rd, .host_wdata,
    .host_rdata, .pacer_tick, .ext_trig, .adc_start, .adc_chan, .adc_valid,
    .adc_data, .gain_code, .irq_a, .irq_b);

  logic [1:0]  lat;
  logic [3:0]  cap_ch;
  logic [11:0] mseq;
  always @(posedge clk) begin
    if (!rst_n) begin
      lat <= 0; adc_valid <= 0; mseq <= 0; adc_data <= 0; cap_ch <= 0;
    end else begin
      adc_valid <= 0;
      if (adc_start) begin
        lat <= 3; cap_ch <= adc_chan;
      end else if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          adc_valid <= 1; adc_data <= {cap_ch, mseq}; mseq <= mseq + 1;
        end
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] v);
    @(negedge clk); host_addr = a; host_rd = 1; #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic pulse_pacer();
    @(negedge clk); pacer_tick = 1; @(negedge clk); pacer_tick = 0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1; @(negedge clk); ext_trig = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_conv(input logic [3:0] ch, input bit kept);
    if (kept) expq.push_back({ch, eseq});
    eseq++;
  endtask

  task automatic pop_check(input string rq);
    logic [15:0] v;
    rd(7'h00, v);
    if (expq.size() == 0) chk(rq, v, 16'hxxxx);
    else chk(rq, v, expq.pop_front());
  endtask

  task automatic stat_check(input string rq, input logic [7:0] exp);
    logic [15:0] v;
    rd(7'h08, v);
    chk(rq, v, {8'h00, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    stat_check("R1 status", 8'h60);
    rd(7'h0A, v); chk("R1 trig", v, 16'h0000);
    chk("R1 irq", {irq_a, irq_b}, 2'b00);

    // R11 gain code
    wr(7'h06, 8'h05);
    wr(7'h08, 8'h03);
    stat_check("R11 status gain", 8'h63);
    chk("R11 gain_code", gain_code, 3'd3);

    // R2 / R10 single software conversion
    wr(7'h0E, 8'h00); expect_conv(4'd5, 1);
    settle();
    stat_check("R2 one sample", 8'h73);
    pop_check("R10 oldest sample");
    stat_check("R2 empty again", 8'h63);

    // R7 second request while busy
    wr(7'h0E, 8'h00); expect_conv(4'd5, 1);
    wr(7'h0E, 8'h00);
    settle(); settle();
    pop_check("R7 first kept");
    stat_check("R7 no duplicate", 8'h63);

    // R6 pacer source
    wr(7'h0A, 8'h02);
    wr(7'h0E, 8'h00); settle();
    stat_check("R6 soft ignored under pacer", 8'h63);
    pulse_ext(); settle();
    stat_check("R6 ext ignored under pacer", 8'h63);
    pulse_pacer(); expect_conv(4'd5, 1); settle();
    pop_check("R6 pacer conversion");
    // R6 external source
    wr(7'h0A, 8'h04);
    pulse_pacer(); settle();
    stat_check("R6 pacer ignored under ext", 8'h63);
    pulse_ext(); expect_conv(4'd5, 1); settle();
    pop_check("R6 ext conversion");

    // R4 auto-scan wrap
    wr(7'h06, 8'h02);
    wr(7'h0A, 8'h05);
    for (int i = 0; i < 5; i++) begin
      pulse_ext(); expect_conv(4'(i % 3), 1); settle();
    end
    for (int i = 0; i < 5; i++) pop_check("R4 scan order");
    wr(7'h0A, 8'h00);
    wr(7'h0E, 8'h00); expect_conv(4'd2, 1); settle();
    pop_check("R4 fixed channel");

    // R8 readback
    wr(7'h0C, 8'h03);
    wr(7'h0A, 8'h05);
    rd(7'h0A, v); chk("R8 readback", v, 16'h0035);
    wr(7'h0A, 8'h00);

    // R9 interrupt sources
    wr(7'h48, 8'h00);
    chk("R9 cleared", {irq_a, irq_b}, 2'b00);
    pulse_pacer();
    chk("R9 pacer not selected", irq_b, 1'b0);
    pulse_ext();
    chk("R9 ext sets irq_b", irq_b, 1'b1);
    wr(7'h48, 8'h00);
    chk("R9 clear irq_b", irq_b, 1'b0);
    wr(7'h0C, 8'h00);
    wr(7'h0E, 8'h00); expect_conv(4'd2, 1); settle();
    chk("R9 eoc sets irq_a", irq_a, 1'b1);
    wr(7'h48, 8'h00);
    chk("R9 clear irq_a", irq_a, 1'b0);

    // R3 reset pattern: one sample present
    wr(7'h0C, 8'h00); wr(7'h0C, 8'h04); wr(7'h0C, 8'h04); wr(7'h0C, 8'h00);
    stat_check("R3 broken pattern keeps data", 8'h73);
    wr(7'h0C, 8'h04); wr(7'h0C, 8'h00);
    stat_check("R3 reset empties", 8'h63);
    expq.delete();

    // R5 depth, half, full, drop
    wr(7'h0C, 8'h01);
    wr(7'h48, 8'h00);
    wr(7'h06, 8'h07);
    for (int i = 0; i < 511; i++) begin
      wr(7'h0E, 8'h00); expect_conv(4'd7, 1); repeat (5) @(negedge clk);
    end
    stat_check("R5 below half", 8'h73);
    chk("R9 no half irq yet", irq_a, 1'b0);
    wr(7'h0E, 8'h00); expect_conv(4'd7, 1); repeat (5) @(negedge clk);
    stat_check("R5 half at 512", 8'h53);
    chk("R9 half irq", irq_a, 1'b1);
    for (int i = 0; i < 512; i++) begin
      wr(7'h0E, 8'h00); expect_conv(4'd7, 1); repeat (5) @(negedge clk);
    end
    stat_check("R5 full at 1024", 8'h13);
    wr(7'h0E, 8'h00); expect_conv(4'd7, 0); repeat (5) @(negedge clk);
    pop_check("R5 oldest after drop");
    stat_check("R5 full sticky", 8'h13);
    wr(7'h0C, 8'h00); wr(7'h0C, 8'h04); wr(7'h0C, 8'h00);
    stat_check("R3 reset releases full", 8'h63);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule